// File: doc/BRIEF.md
# Dual-Channel External Interrupt Detector

This block turns signals on an 8-bit input port into interrupt requests for a CPU. It has two independent channels. Each channel picks one port bit through its own 3-bit pin-select field. The bit is only read, so the pin stays free for whatever other logic drives or samples it. The selected bit passes through a synchroniser. A per-channel polarity bit then decides whether high or low counts as active. A per-channel mode bit chooses edge or level sensitivity.

In edge mode a channel latches an inactive-to-active transition into its pending flag. The flag stays set until the CPU's vector-acknowledge pulse for that channel clears it, or until a software write-one-to-clear strobe does. In level mode nothing is stored: the pending flag simply tracks whether the synchronised input is currently active. A source that is still asserted after service therefore raises a new request at once. Each channel's request output mirrors its pending flag. Priority arbitration and vector generation are left to the interrupt controller that consumes these requests.

Top module: `ext_irq_detect`

## Requirements
- R1: Channel c samples port bit number `pin_sel[3c+2:3c]`, where the 3-bit value is the bit index 0 to 7. The other seven port bits have no effect on that channel.
- R2: Polarity bit `pol_high[c]` = 1 makes a high input active, and 0 makes a low input active. In edge mode, an active-to-inactive transition never sets the flag.
- R3: With `edge_mode[c]` = 0 (level), `pending[c]` is 1 exactly while the selected pin is active, two clock edges after the pin changes. `vec_ack` and `sw_clear` do not alter it, and it stays 1 after an acknowledge while the pin is still active.
- R4: With `edge_mode[c]` = 1 (edge), an inactive-to-active change on the selected pin sets `pending[c]` on the third clock edge after the change, and not before.
- R5: In edge mode a set flag stays 1 after the pin returns inactive. A pin held active does not set the flag again after it has been cleared.
- R6: In edge mode, a `vec_ack[c]` pulse clears `pending[c]` on the next clock edge.
- R7: In edge mode, a `sw_clear[c]` pulse clears `pending[c]` on the next clock edge.
- R8: If an edge is detected in the same cycle as `vec_ack[c]` or `sw_clear[c]`, the flag ends up set.
- R9: `irq_req[c]` always equals `pending[c]`.
- R10: The two channels are independent: an acknowledge or clear on one channel leaves the other channel's flag unchanged.
- R11: Reset clears both flags. A pin that is already active while reset is released does not count as an edge. Level-mode pending stays 0 until the synchroniser holds a real sample.
- R12: While a channel is in level mode its stored edge flag is held clear. Switching that channel to edge mode therefore shows pending 0 until a new edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_in | input | 8 | Monitored port pins, read only |
| pin_sel | input | 6 | Pin index per channel, 3 bits each, channel 0 in bits 2:0 |
| pol_high | input | 2 | Per-channel polarity, 1 = active high |
| edge_mode | input | 2 | Per-channel sensitivity, 1 = edge, 0 = level |
| vec_ack | input | 2 | Per-channel CPU vector-acknowledge pulse |
| sw_clear | input | 2 | Per-channel write-one-to-clear strobe |
| pending | output | 2 | Per-channel interrupt-pending flag |
| irq_req | output | 2 | Per-channel interrupt request |

## Verification
A change on a port pin reaches the level-mode flag two rising edges later, because two synchroniser flops sit in the path. It reaches the edge-mode flag three rising edges later, once the previous-sample register also updates. Acknowledge and clear pulses act on the first rising edge. The bench changes inputs on falling edges and counts rising edges explicitly before sampling on a falling edge. It also checks one cycle early, to show that a flag does not appear before it is due. The sweep covers every pin, both polarities, both modes and both channels. The same-cycle priority case is placed on the exact edge where the set is registered.

// File: rtl/eid_pkg.sv
package eid_pkg;

   typedef enum logic {
      SENSE_LEVEL = 1'b0,
      SENSE_EDGE  = 1'b1
   } sense_e;

   // Map a raw pin sample onto "active" under the given polarity.
   function automatic logic act_of(input logic raw, input logic pol_hi);
      return pol_hi ? raw : ~raw;
   endfunction

endpackage

// File: rtl/eid_pin_mux.sv
module eid_pin_mux #(
   parameter int PORT_W = 8,
   parameter int SEL_W  = 3
) (
   input  logic [PORT_W-1:0] port_in,
   input  logic [SEL_W-1:0]  sel,
   output logic              pin
);

   localparam int FULL_RANGE = (PORT_W == (1 << SEL_W)) ? 1 : 0;

   generate
      if (FULL_RANGE == 1) begin : g_direct
         // Every select code names a real pin.
         assign pin = port_in[sel];
      end else begin : g_checked
         // Codes beyond the port read as 0.
         always_comb begin
            pin = 1'b0;
            for (int i = 0; i < PORT_W; i++) begin
               if (sel == SEL_W'(i)) pin = port_in[i];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/eid_sync.sv
module eid_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/eid_channel.sv
module eid_channel
   import eid_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic raw_sync,   // synchronised pin sample
   input  logic sync_ok,    // raw_sync holds a real sample
   input  logic prev_ok,    // previous sample is real too
   input  logic pol_high,
   input  logic edge_mode,
   input  logic vec_ack,
   input  logic sw_clear,
   output logic pending
);

   sense_e sense;
   logic   prev_q;
   logic   flag_q;
   logic   flag_d;
   logic   act_now;
   logic   act_prev;
   logic   edge_hit;
   logic   level_act;

   assign sense = sense_e'(edge_mode);

   // The raw previous sample is kept, and both samples are qualified with
   // the current polarity, so a polarity change alone never forms an edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= raw_sync;
   end

   assign act_now   = act_of(raw_sync, pol_high);
   assign act_prev  = act_of(prev_q, pol_high);
   assign edge_hit  = prev_ok & act_now & ~act_prev;
   assign level_act = sync_ok & act_now;

   always_comb begin
      flag_d = flag_q;
      if (sense == SENSE_LEVEL)       flag_d = 1'b0;
      else if (edge_hit)              flag_d = 1'b1;  // set beats clear
      else if (vec_ack || sw_clear)   flag_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assign pending = (sense == SENSE_EDGE) ? flag_q : level_act;

   assert_edge_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && edge_hit) |=> flag_q);

   assert_no_spurious_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && !flag_q && !edge_hit) |=> !flag_q);

   assert_flag_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && flag_q && !vec_ack && !sw_clear) |=> flag_q);

   assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && vec_ack && !edge_hit) |=> !flag_q);

   assert_sw_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && sw_clear && !edge_hit) |=> !flag_q);

   assert_level_stores_nothing_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_mode |=> !flag_q);

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
   parameter int NUM_CH      = 2,
   parameter int PORT_W      = 8,
   parameter int SEL_W       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [PORT_W-1:0]       port_in,
   input  logic [NUM_CH*SEL_W-1:0] pin_sel,
   input  logic [NUM_CH-1:0]       pol_high,
   input  logic [NUM_CH-1:0]       edge_mode,
   input  logic [NUM_CH-1:0]       vec_ack,
   input  logic [NUM_CH-1:0]       sw_clear,
   output logic [NUM_CH-1:0]       pending,
   output logic [NUM_CH-1:0]       irq_req
);

   localparam int FILL_W = SYNC_STAGES + 1;

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("ext_irq_detect: NUM_CH must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ext_irq_detect: SYNC_STAGES must be at least 2");
      end
      if ((1 << SEL_W) < PORT_W) begin : g_bad_sel
         $error("ext_irq_detect: SEL_W too narrow for PORT_W");
      end
   endgenerate

   // Shared fill marker: bit k is set after k+1 edges out of reset.
   logic [FILL_W-1:0] fill_q;
   logic              sync_ok;
   logic              prev_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fill_q <= '0;
      else        fill_q <= {fill_q[FILL_W-2:0], 1'b1};
   end

   assign sync_ok = fill_q[SYNC_STAGES-1];
   assign prev_ok = fill_q[SYNC_STAGES];

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic pin_raw;
         logic pin_sync;

         eid_pin_mux #(.PORT_W(PORT_W), .SEL_W(SEL_W)) u_mux (
            .port_in (port_in),
            .sel     (pin_sel[c*SEL_W +: SEL_W]),
            .pin     (pin_raw)
         );

         eid_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pin_raw),
            .q     (pin_sync)
         );

         eid_channel u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw_sync  (pin_sync),
            .sync_ok   (sync_ok),
            .prev_ok   (prev_ok),
            .pol_high  (pol_high[c]),
            .edge_mode (edge_mode[c]),
            .vec_ack   (vec_ack[c]),
            .sw_clear  (sw_clear[c]),
            .pending   (pending[c])
         );
      end
   endgenerate

   assign irq_req = pending;

   assert_fill_order_R11: assert property (@(posedge clk) disable iff (!rst_n)
      prev_ok |-> sync_ok);

   assert_no_level_before_fill_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_ok |-> (pending == '0));

endmodule

// File: tb/tb_ext_irq_detect.sv
module tb_ext_irq_detect;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] port_in;
   logic [5:0] pin_sel;
   logic [1:0] pol_high;
   logic [1:0] edge_mode;
   logic [1:0] vec_ack;
   logic [1:0] sw_clear;
   logic [1:0] pending;
   logic [1:0] irq_req;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 0;

   always #2 clk = ~clk;   // 250 MHz

   ext_irq_detect dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .port_in   (port_in),
      .pin_sel   (pin_sel),
      .pol_high  (pol_high),
      .edge_mode (edge_mode),
      .vec_ack   (vec_ack),
      .sw_clear  (sw_clear),
      .pending   (pending),
      .irq_req   (irq_req)
   );

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   // Checks the flag and the request (R9) of one channel.
   task automatic chk_ch(input string tag, input int ch, input logic exp);
      chk(tag, pending[ch], exp);
      chk({tag, " / R9 request"}, irq_req[ch], exp);
   endtask

   task automatic cfg(input int ch, input int sel, input bit pol, input bit mode);
      pin_sel[ch*3 +: 3] = sel[2:0];
      pol_high[ch]       = pol;
      edge_mode[ch]      = mode;
   endtask

   task automatic pulse_ack(input int ch);
      vec_ack[ch] = 1'b1;
      cyc(1);
      vec_ack[ch] = 1'b0;
   endtask

   task automatic pulse_clr(input int ch);
      sw_clear[ch] = 1'b1;
      cyc(1);
      sw_clear[ch] = 1'b0;
   endtask

   // Port value with the selected pin and all other pins set active/inactive.
   function automatic logic [7:0] mk(input int p, input bit pol,
                                     input bit pin_act, input bit others_act);
      logic [7:0] v;
      v    = {8{others_act ? pol : ~pol}};
      v[p] = pin_act ? pol : ~pol;
      return v;
   endfunction

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog (all requirements) actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n     = 1'b0;
      port_in   = 8'h00;
      pin_sel   = '0;
      pol_high  = '0;
      edge_mode = 2'b11;
      vec_ack   = '0;
      sw_clear  = '0;
      cyc(3);
      chk_ch("R11 reset ch0", 0, 1'b0);
      chk_ch("R11 reset ch1", 1, 1'b0);
      rst_n = 1'b1;
      cyc(4);

      // Level-mode sweep: R1, R2, R3
      for (int ch = 0; ch < 2; ch++) begin
         for (int p = 0; p < 8; p++) begin
            for (int pol = 0; pol < 2; pol++) begin
               cfg(ch, p, pol[0], 1'b0);
               port_in = mk(p, pol[0], 1'b0, 1'b0);
               cyc(3);
               chk_ch("R2 level idle", ch, 1'b0);
               port_in = mk(p, pol[0], 1'b0, 1'b1);
               cyc(3);
               chk_ch("R1 other pins active", ch, 1'b0);
               port_in = mk(p, pol[0], 1'b1, 1'b0);
               cyc(1);
               chk_ch("R3 one edge after activate", ch, 1'b0);
               cyc(1);
               chk_ch("R3 two edges after activate", ch, 1'b1);
               pulse_ack(ch);
               chk_ch("R3 ack leaves level flag", ch, 1'b1);
               pulse_clr(ch);
               chk_ch("R3 clear leaves level flag", ch, 1'b1);
               port_in = mk(p, pol[0], 1'b0, 1'b0);
               cyc(1);
               chk_ch("R3 one edge after release", ch, 1'b1);
               cyc(1);
               chk_ch("R3 two edges after release", ch, 1'b0);
            end
         end
      end

      // Edge-mode sweep: R2, R4, R5, R6, R7
      for (int ch = 0; ch < 2; ch++) begin
         for (int p = 0; p < 8; p++) begin
            for (int pol = 0; pol < 2; pol++) begin
               cfg(ch, p, pol[0], 1'b1);
               port_in = mk(p, pol[0], 1'b0, 1'b0);
               cyc(4);
               pulse_clr(ch);
               chk_ch("R7 start cleared", ch, 1'b0);
               port_in = mk(p, pol[0], 1'b1, 1'b0);
               cyc(2);
               chk_ch("R4 not set after two edges", ch, 1'b0);
               cyc(1);
               chk_ch("R4 set after three edges", ch, 1'b1);
               pulse_ack(ch);
               chk_ch("R6 ack clears", ch, 1'b0);
               cyc(4);
               chk_ch("R5 held active no re-set", ch, 1'b0);
               port_in = mk(p, pol[0], 1'b0, 1'b0);
               cyc(4);
               chk_ch("R2 inactive edge ignored", ch, 1'b0);
               port_in = mk(p, pol[0], 1'b1, 1'b0);
               cyc(3);
               chk_ch("R4 second edge", ch, 1'b1);
               port_in = mk(p, pol[0], 1'b0, 1'b0);
               cyc(4);
               chk_ch("R5 latched after release", ch, 1'b1);
               pulse_clr(ch);
               chk_ch("R7 clear strobe", ch, 1'b0);
            end
         end
      end

      // R8: set wins over ack, then over clear
      cfg(0, 0, 1'b1, 1'b1);
      cfg(1, 7, 1'b1, 1'b1);
      port_in = 8'h00;
      cyc(4);
      pulse_clr(0);
      pulse_clr(1);
      port_in = 8'h01;
      cyc(2);
      vec_ack[0] = 1'b1;
      cyc(1);
      vec_ack[0] = 1'b0;
      chk_ch("R8 set beats ack", 0, 1'b1);
      port_in = 8'h00;
      cyc(4);
      pulse_clr(0);
      chk_ch("R7 clear before R8 clear case", 0, 1'b0);
      port_in = 8'h01;
      cyc(2);
      sw_clear[0] = 1'b1;
      cyc(1);
      sw_clear[0] = 1'b0;
      chk_ch("R8 set beats clear", 0, 1'b1);

      // R10: channel independence
      cfg(0, 2, 1'b1, 1'b1);
      cfg(1, 5, 1'b0, 1'b1);
      port_in = 8'b0010_0000;
      cyc(4);
      pulse_clr(0);
      pulse_clr(1);
      port_in = 8'b0000_0100;
      cyc(3);
      chk_ch("R10 ch0 set", 0, 1'b1);
      chk_ch("R10 ch1 set", 1, 1'b1);
      pulse_ack(0);
      chk_ch("R10 ch0 acked", 0, 1'b0);
      chk_ch("R10 ch1 untouched by ch0 ack", 1, 1'b1);
      pulse_clr(1);
      chk_ch("R10 ch1 cleared", 1, 1'b0);
      chk_ch("R10 ch0 stays clear", 0, 1'b0);

      // R12: level to edge switch shows no stale flag
      cfg(0, 0, 1'b1, 1'b0);
      port_in = 8'h01;
      cyc(3);
      chk_ch("R12 level active", 0, 1'b1);
      edge_mode[0] = 1'b1;
      cyc(1);
      chk_ch("R12 edge mode after switch", 0, 1'b0);

      // R11: reset release with active pin / masked level
      cfg(0, 3, 1'b1, 1'b1);
      cfg(1, 4, 1'b0, 1'b0);
      port_in = 8'b0001_1000;
      rst_n = 1'b0;
      cyc(2);
      chk_ch("R11 in reset ch0", 0, 1'b0);
      chk_ch("R11 in reset ch1", 1, 1'b0);
      rst_n = 1'b1;
      cyc(1);
      chk_ch("R11 level masked during fill", 1, 1'b0);
      cyc(5);
      chk_ch("R11 active pin at release is no edge", 0, 1'b0);
      chk_ch("R11 inactive level pin", 1, 1'b0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule